// File: doc/BRIEF.md
# Instruction Decoder with Execute-Stage Control Register

This block turns a 14-bit instruction word of a small accumulator machine into the control bundle that the execute stage consumes. The bundle selects ALU operand A, selects ALU operand B, enables the write to the accumulator W, enables the write to data RAM, gives the ALU operation, and flags jump and return. The bundle is held in a register, so the execute stage works on one instruction while the next one is being decoded.

The decoder keeps the ALU operation set small. Some instructions have no ALU operation of their own and are built from constant operands instead. A store of W becomes "zero plus W", a clear becomes a pass of constant zero, and increment and decrement become add or subtract with constant one. A skip input from the control unit cancels the commit of the next instruction. That instruction still passes through the ALU, but both of its write enables are held low. The ALU, the data RAM, the program counter and the interrupt logic are outside this block.

Top module: `instr_decoder`

## Requirements
- R1: While rst_ni is low, the registered bundle is the idle bundle: every output is 0.
- R2: The outputs change only on a rising clock edge, and they show the decode of the instruction_i and not_skip_i values sampled at that edge. The encodings are: a_sel_o literal=0, file=1, zero=2. b_sel_o W=0, one=1, zero=2. alu_op_o pass-A=0, and=1, or=2, xor=3, not-A=4, A-minus-B=5, add=6, shift-left=7, shift-right=8, bit-set=9, bit-test=10, nibble-swap=11, bit-clear=12. For every instruction, any field that the requirements below do not name is 0.
- R3: Load-literal (bits 13:10 = 1100) gives wr_w_o=1, alu_op_o=pass, a_sel_o=literal, and every other output 0.
- R4: branch_o is 1 only for call (bits 13:11 = 100) and goto (bits 13:11 = 101). For these two, every other output is 0.
- R5: ret_o is 1 for return (0x0008), return-from-interrupt (0x0009) and return-with-literal (bits 13:10 = 1101). Return-with-literal also sets wr_w_o=1 with pass of the literal.
- R6: Store-W (bits 13:7 = 0000001) gives alu_op_o=add, a_sel_o=zero, b_sel_o=W, wr_ram_o=1, wr_w_o=0.
- R7: Clear (bits 13:8 = 000001) gives alu_op_o=pass, a_sel_o=zero, b_sel_o=zero. Bit 7 = 1 sets wr_ram_o, and bit 7 = 0 sets wr_w_o.
- R8: Increment (bits 13:8 = 001010, or 001111 for the skip form) gives add, and decrement (000011, or 001011) gives A-minus-B. Both use a_sel_o=file and b_sel_o=one, and the destination follows bit 7.
- R9: The file-with-W group uses a_sel_o=file and b_sel_o=W. Bit 7 = 0 writes W and bit 7 = 1 writes RAM, never both. Codes in bits 11:8: 0010 A-minus-B, 0100 or, 0101 and, 0110 xor, 0111 add, 1000 pass, 1001 not, 1100 shift-right, 1101 shift-left, 1110 swap.
- R10: Bit ops (bits 13:12 = 01) use a_sel_o=file. Bits 11:10 = 00 gives bit-clear with wr_ram_o=1. 01 gives bit-set with wr_ram_o=1. 1x gives bit-test with no write.
- R11: Literal ALU ops (bits 13:12 = 11) use a_sel_o=literal, b_sel_o=W and wr_w_o=1. Codes in bits 11:8: 1000 or, 1001 and, 1010 xor, 110x A-minus-B, 111x add.
- R12: When not_skip_i is 0 at an edge, the bundle captured at that edge has wr_w_o=0 and wr_ram_o=0, and every other field is decoded as usual.
- R13: Undefined words decode to the idle bundle with all outputs 0. This covers 0x0000, any word with bits 13:7 = 0000000 other than 0x0008 and 0x0009, and bits 13:8 = 111011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 14 | Instruction word in the decode stage |
| not_skip_i | input | 1 | 0 cancels the writes of the instruction now being captured |
| a_sel_o | output | 2 | ALU operand A source |
| b_sel_o | output | 2 | ALU operand B source |
| wr_w_o | output | 1 | Write the ALU result to W |
| wr_ram_o | output | 1 | Write the ALU result to the addressed RAM location |
| alu_op_o | output | 4 | ALU operation |
| branch_o | output | 1 | Call or goto in the execute stage |
| ret_o | output | 1 | Return of any kind in the execute stage |

## Verification
A wrong group or operation code inside the decoder shows up in the bundle exactly one edge after the instruction is presented. For example, a destination bit that lands on the wrong enable, or a constant operand that lands on the wrong port. Nothing is stored beyond that single register, so an error never shows later than the next cycle and never carries into the instruction after it. A squash that fails shows as a write enable high in the cycle after not_skip_i was low. A register that does not update shows as the previous instruction's bundle appearing one cycle late.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

  localparam int INSTR_W = 14;
  localparam int DEST_POS = 7;

  typedef enum logic [1:0] {
    SRC_A_LIT  = 2'd0,
    SRC_A_FILE = 2'd1,
    SRC_A_ZERO = 2'd2
  } src_a_e;

  typedef enum logic [1:0] {
    SRC_B_W    = 2'd0,
    SRC_B_ONE  = 2'd1,
    SRC_B_ZERO = 2'd2
  } src_b_e;

  typedef enum logic [3:0] {
    ALU_PASS  = 4'd0,
    ALU_AND   = 4'd1,
    ALU_OR    = 4'd2,
    ALU_XOR   = 4'd3,
    ALU_NOT   = 4'd4,
    ALU_SUB   = 4'd5,
    ALU_ADD   = 4'd6,
    ALU_SHL   = 4'd7,
    ALU_SHR   = 4'd8,
    ALU_BSET  = 4'd9,
    ALU_BTEST = 4'd10,
    ALU_SWAP  = 4'd11,
    ALU_BCLR  = 4'd12
  } alu_op_e;

  // instruction groups; members of a group share operand routing and write rule
  typedef enum logic [3:0] {
    GRP_NONE,
    GRP_RET,
    GRP_STORE,
    GRP_CLEAR,
    GRP_FILE_W,
    GRP_FILE_ONE,
    GRP_BIT_WR,
    GRP_BIT_TEST,
    GRP_LIT,
    GRP_LIT_RET,
    GRP_JUMP
  } grp_e;

  typedef struct packed {
    src_a_e  a_sel;
    src_b_e  b_sel;
    logic    wr_w;
    logic    wr_ram;
    alu_op_e op;
    logic    branch;
    logic    ret;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{
    a_sel:  SRC_A_LIT,
    b_sel:  SRC_B_W,
    wr_w:   1'b0,
    wr_ram: 1'b0,
    op:     ALU_PASS,
    branch: 1'b0,
    ret:    1'b0
  };

endpackage

// File: rtl/instr_dec_class.sv
module instr_dec_class
  import instr_dec_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0] instr_i,
  output grp_e          grp_o,
  output alu_op_e       op_o
);

  localparam int TOP = IW - 1;
  localparam logic [6:0] RET_LO  = 7'h08;
  localparam logic [6:0] RETI_LO = 7'h09;

  logic [1:0] major;
  logic [3:0] minor;

  assign major = instr_i[TOP -: 2];
  assign minor = instr_i[TOP-2 -: 4];

  always_comb begin
    grp_o = GRP_NONE;
    op_o  = ALU_PASS;
    unique case (major)
      2'b00: begin
        unique case (minor)
          4'b0000: begin
            if (instr_i[DEST_POS]) begin
              grp_o = GRP_STORE;
              op_o  = ALU_ADD;
            end else if (instr_i[6:0] == RET_LO || instr_i[6:0] == RETI_LO) begin
              grp_o = GRP_RET;
            end
          end
          4'b0001: grp_o = GRP_CLEAR;
          4'b0010: begin grp_o = GRP_FILE_W;   op_o = ALU_SUB;  end
          4'b0011: begin grp_o = GRP_FILE_ONE; op_o = ALU_SUB;  end
          4'b0100: begin grp_o = GRP_FILE_W;   op_o = ALU_OR;   end
          4'b0101: begin grp_o = GRP_FILE_W;   op_o = ALU_AND;  end
          4'b0110: begin grp_o = GRP_FILE_W;   op_o = ALU_XOR;  end
          4'b0111: begin grp_o = GRP_FILE_W;   op_o = ALU_ADD;  end
          4'b1000: begin grp_o = GRP_FILE_W;   op_o = ALU_PASS; end
          4'b1001: begin grp_o = GRP_FILE_W;   op_o = ALU_NOT;  end
          4'b1010: begin grp_o = GRP_FILE_ONE; op_o = ALU_ADD;  end
          4'b1011: begin grp_o = GRP_FILE_ONE; op_o = ALU_SUB;  end
          4'b1100: begin grp_o = GRP_FILE_W;   op_o = ALU_SHR;  end
          4'b1101: begin grp_o = GRP_FILE_W;   op_o = ALU_SHL;  end
          4'b1110: begin grp_o = GRP_FILE_W;   op_o = ALU_SWAP; end
          4'b1111: begin grp_o = GRP_FILE_ONE; op_o = ALU_ADD;  end
          default: grp_o = GRP_NONE;
        endcase
      end
      2'b01: begin
        unique case (minor[3:2])
          2'b00:   begin grp_o = GRP_BIT_WR;   op_o = ALU_BCLR;  end
          2'b01:   begin grp_o = GRP_BIT_WR;   op_o = ALU_BSET;  end
          default: begin grp_o = GRP_BIT_TEST; op_o = ALU_BTEST; end
        endcase
      end
      2'b10: grp_o = GRP_JUMP;
      default: begin
        unique casez (minor)
          4'b00??: grp_o = GRP_LIT;
          4'b01??: grp_o = GRP_LIT_RET;
          4'b1000: begin grp_o = GRP_LIT; op_o = ALU_OR;  end
          4'b1001: begin grp_o = GRP_LIT; op_o = ALU_AND; end
          4'b1010: begin grp_o = GRP_LIT; op_o = ALU_XOR; end
          4'b110?: begin grp_o = GRP_LIT; op_o = ALU_SUB; end
          4'b111?: begin grp_o = GRP_LIT; op_o = ALU_ADD; end
          default: grp_o = GRP_NONE;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/instr_dec_map.sv
module instr_dec_map
  import instr_dec_pkg::*;
(
  input  grp_e    grp_i,
  input  alu_op_e op_i,
  input  logic    dest_ram_i,
  output ctrl_t   ctrl_o
);

  always_comb begin
    ctrl_o = CTRL_IDLE;
    unique case (grp_i)
      GRP_RET: ctrl_o.ret = 1'b1;
      GRP_STORE: begin
        // store W as zero + W, no pass-B op needed
        ctrl_o.a_sel  = SRC_A_ZERO;
        ctrl_o.b_sel  = SRC_B_W;
        ctrl_o.op     = op_i;
        ctrl_o.wr_ram = 1'b1;
      end
      GRP_CLEAR: begin
        ctrl_o.a_sel  = SRC_A_ZERO;
        ctrl_o.b_sel  = SRC_B_ZERO;
        ctrl_o.op     = ALU_PASS;
        ctrl_o.wr_ram = dest_ram_i;
        ctrl_o.wr_w   = !dest_ram_i;
      end
      GRP_FILE_W: begin
        ctrl_o.a_sel  = SRC_A_FILE;
        ctrl_o.b_sel  = SRC_B_W;
        ctrl_o.op     = op_i;
        ctrl_o.wr_ram = dest_ram_i;
        ctrl_o.wr_w   = !dest_ram_i;
      end
      GRP_FILE_ONE: begin
        ctrl_o.a_sel  = SRC_A_FILE;
        ctrl_o.b_sel  = SRC_B_ONE;
        ctrl_o.op     = op_i;
        ctrl_o.wr_ram = dest_ram_i;
        ctrl_o.wr_w   = !dest_ram_i;
      end
      GRP_BIT_WR: begin
        ctrl_o.a_sel  = SRC_A_FILE;
        ctrl_o.op     = op_i;
        ctrl_o.wr_ram = 1'b1;
      end
      GRP_BIT_TEST: begin
        ctrl_o.a_sel = SRC_A_FILE;
        ctrl_o.op    = op_i;
      end
      GRP_LIT: begin
        ctrl_o.a_sel = SRC_A_LIT;
        ctrl_o.b_sel = SRC_B_W;
        ctrl_o.op    = op_i;
        ctrl_o.wr_w  = 1'b1;
      end
      GRP_LIT_RET: begin
        ctrl_o.a_sel = SRC_A_LIT;
        ctrl_o.op    = ALU_PASS;
        ctrl_o.wr_w  = 1'b1;
        ctrl_o.ret   = 1'b1;
      end
      GRP_JUMP: ctrl_o.branch = 1'b1;
      default: ctrl_o = CTRL_IDLE;
    endcase
  end

endmodule

// File: rtl/instr_dec_stage.sv
module instr_dec_stage
  import instr_dec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  not_skip_i,
  output ctrl_t ctrl_o
);

  ctrl_t gated;

  always_comb begin
    gated = ctrl_i;
    // squashed instruction still flows to the ALU but commits nothing
    if (!not_skip_i) begin
      gated.wr_w   = 1'b0;
      gated.wr_ram = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= CTRL_IDLE;
    else         ctrl_o <= gated;
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] instr_i,
  input  logic          not_skip_i,
  output logic [1:0]    a_sel_o,
  output logic [1:0]    b_sel_o,
  output logic          wr_w_o,
  output logic          wr_ram_o,
  output logic [3:0]    alu_op_o,
  output logic          branch_o,
  output logic          ret_o
);

  grp_e    grp;
  alu_op_e op;
  ctrl_t   ctrl_d;
  ctrl_t   ctrl_q;

  instr_dec_class #(.IW(IW)) u_class (
    .instr_i (instr_i),
    .grp_o   (grp),
    .op_o    (op)
  );

  instr_dec_map u_map (
    .grp_i      (grp),
    .op_i       (op),
    .dest_ram_i (instr_i[DEST_POS]),
    .ctrl_o     (ctrl_d)
  );

  instr_dec_stage u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl_d),
    .not_skip_i (not_skip_i),
    .ctrl_o     (ctrl_q)
  );

  assign a_sel_o  = ctrl_q.a_sel;
  assign b_sel_o  = ctrl_q.b_sel;
  assign wr_w_o   = ctrl_q.wr_w;
  assign wr_ram_o = ctrl_q.wr_ram;
  assign alu_op_o = ctrl_q.op;
  assign branch_o = ctrl_q.branch;
  assign ret_o    = ctrl_q.ret;

endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
  parameter int IW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] instr_i,
  input logic          not_skip_i,
  input logic [1:0]    a_sel_o,
  input logic [1:0]    b_sel_o,
  input logic          wr_w_o,
  input logic          wr_ram_o,
  input logic [3:0]    alu_op_o,
  input logic          branch_o,
  input logic          ret_o
);

  p_one_dest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_w_o && wr_ram_o));

  p_squash_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_skip_i |=> !wr_w_o && !wr_ram_o);

  p_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[13:12] == 2'b10 |=> branch_o && !ret_o && !wr_w_o && !wr_ram_o);

  p_no_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[13:12] != 2'b10 |=> !branch_o);

  p_ret_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 14'h0008 || instr_i == 14'h0009) |=> ret_o && !branch_o && !wr_w_o);

  p_lit_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[13:10] == 4'b1100 && not_skip_i |=>
      wr_w_o && !wr_ram_o && alu_op_o == 4'd0 && a_sel_o == 2'd0 && !ret_o);

  p_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[13:7] == 7'b0000001 && not_skip_i |=>
      wr_ram_o && alu_op_o == 4'd6 && a_sel_o == 2'd2 && b_sel_o == 2'd0);

  p_bit_test_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[13:11] == 3'b011 |=> !wr_w_o && !wr_ram_o && alu_op_o == 4'd10);

endmodule

bind instr_decoder instr_decoder_chk #(.IW(IW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_i    (instr_i),
  .not_skip_i (not_skip_i),
  .a_sel_o    (a_sel_o),
  .b_sel_o    (b_sel_o),
  .wr_w_o     (wr_w_o),
  .wr_ram_o   (wr_ram_o),
  .alu_op_o   (alu_op_o),
  .branch_o   (branch_o),
  .ret_o      (ret_o)
);

// File: tb/instr_decoder_test.sv
module instr_decoder_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [13:0] instr_i = 14'h0000;
  logic        not_skip_i = 1'b1;
  logic [1:0]  a_sel_o, b_sel_o;
  logic        wr_w_o, wr_ram_o, branch_o, ret_o;
  logic [3:0]  alu_op_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  instr_decoder uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .instr_i    (instr_i),
    .not_skip_i (not_skip_i),
    .a_sel_o    (a_sel_o),
    .b_sel_o    (b_sel_o),
    .wr_w_o     (wr_w_o),
    .wr_ram_o   (wr_ram_o),
    .alu_op_o   (alu_op_o),
    .branch_o   (branch_o),
    .ret_o      (ret_o)
  );

  // {instr, not_skip, a_sel, b_sel, wr_w, wr_ram, alu_op, branch, ret, req}
  localparam int NV = 32;
  localparam logic [30:0] VEC [NV] = '{
    {14'h3055, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd3},  // R3 load literal
    {14'h34AA, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 4'd5},  // R5 return with literal
    {14'h2123, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd4},  // R4 call
    {14'h2ABC, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd4},  // R4 goto
    {14'h0008, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 4'd5},  // R5 return
    {14'h0009, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 4'd5},  // R5 return from interrupt
    {14'h00A5, 1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 4'd6,  1'b0, 1'b0, 4'd6},  // R6 store W
    {14'h0185, 1'b1, 2'd2, 2'd2, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 4'd7},  // R7 clear file
    {14'h0103, 1'b1, 2'd2, 2'd2, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd7},  // R7 clear W
    {14'h0A85, 1'b1, 2'd1, 2'd1, 1'b0, 1'b1, 4'd6,  1'b0, 1'b0, 4'd8},  // R8 increment to RAM
    {14'h0305, 1'b1, 2'd1, 2'd1, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 4'd8},  // R8 decrement to W
    {14'h0B85, 1'b1, 2'd1, 2'd1, 1'b0, 1'b1, 4'd5,  1'b0, 1'b0, 4'd8},  // R8 decrement-skip to RAM
    {14'h0F20, 1'b1, 2'd1, 2'd1, 1'b1, 1'b0, 4'd6,  1'b0, 1'b0, 4'd8},  // R8 increment-skip to W
    {14'h0720, 1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 4'd6,  1'b0, 1'b0, 4'd9},  // R9 add to W
    {14'h06A0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4'd3,  1'b0, 1'b0, 4'd9},  // R9 xor to RAM
    {14'h0EA0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4'd11, 1'b0, 1'b0, 4'd9},  // R9 swap to RAM
    {14'h0C20, 1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 4'd8,  1'b0, 1'b0, 4'd9},  // R9 shift right to W
    {14'h02A0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4'd5,  1'b0, 1'b0, 4'd9},  // R9 subtract to RAM
    {14'h0920, 1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 4'd4,  1'b0, 1'b0, 4'd9},  // R9 complement to W
    {14'h1683, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4'd9,  1'b0, 1'b0, 4'd10}, // R10 bit set
    {14'h1003, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4'd12, 1'b0, 1'b0, 4'd10}, // R10 bit clear
    {14'h1C03, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 4'd10, 1'b0, 1'b0, 4'd10}, // R10 bit test
    {14'h3E10, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 4'd6,  1'b0, 1'b0, 4'd11}, // R11 add literal
    {14'h3C10, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 4'd11}, // R11 subtract literal
    {14'h3910, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 4'd1,  1'b0, 1'b0, 4'd11}, // R11 and literal
    {14'h3810, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 4'd2,  1'b0, 1'b0, 4'd11}, // R11 or literal
    {14'h3A10, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 4'd3,  1'b0, 1'b0, 4'd11}, // R11 xor literal
    {14'h3B00, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd13}, // R13 undefined literal slot
    {14'h0064, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd13}, // R13 undefined control word
    {14'h0000, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd13}, // R13 zero word
    {14'h07A0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd6,  1'b0, 1'b0, 4'd12}, // R12 squashed add to RAM
    {14'h3055, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd12}  // R12 squashed load literal
  };

  function automatic logic [11:0] bundle();
    return {a_sel_o, b_sel_o, wr_w_o, wr_ram_o, alu_op_o, branch_o, ret_o};
  endfunction

  task automatic check(input logic [11:0] exp, input int req, input string what);
    checks++;
    if (bundle() !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %03h expected %03h", req, what, bundle(), exp);
    end
  endtask

  task automatic apply(input logic [13:0] ins, input logic ns);
    @(negedge clk_i);
    instr_i = ins;
    not_skip_i = ns;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2 rst_ni = 1'b0;
    instr_i = 14'h3055;
    repeat (2) @(posedge clk_i);
    #1;
    check(12'h000, 1, "R1 idle bundle under reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:17], VEC[i][16]);
      check(VEC[i][15:4], int'(VEC[i][3:0]), $sformatf("vector %0d instr %04h", i, VEC[i][30:17]));
    end

    // R2: output holds until the edge, then takes the new decode
    apply(14'h2123, 1'b1);
    @(negedge clk_i);
    instr_i = 14'h0720;
    #2;
    check(12'h002, 2, "R2 held before edge");
    @(posedge clk_i);
    #1;
    check({2'd1, 2'd0, 1'b1, 1'b0, 4'd6, 1'b0, 1'b0}, 2, "R2 updated after edge");

    // R12: squash affects only one bundle
    apply(14'h0A85, 1'b0);
    check({2'd1, 2'd1, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0}, 12, "R12 squashed increment");
    apply(14'h0A85, 1'b1);
    check({2'd1, 2'd1, 1'b0, 1'b1, 4'd6, 1'b0, 1'b0}, 12, "R12 next bundle writes again");

    // R1: asynchronous reset mid-run
    apply(14'h34AA, 1'b1);
    #2 rst_ni = 1'b0;
    #1;
    check(12'h000, 1, "R1 asynchronous clear");
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule